// File: doc/BRIEF.md
# Banked GPIO Port Block

This block controls 29 general-purpose pins grouped into four byte-wide ports. Pin n sits in port n/8 at bit n%8, and the last port holds only five pins. A host reaches each port through one data byte at a fixed offset. Writing the byte loads that port's output latches. Reading it returns, bit by bit, either the latched value (for a pin whose output is enabled) or the synchronized level on the pad (for a pin used as an input). This means that a read-modify-write aimed at one pin leaves the other driven pins as they were.

The drive of each pin is set by per-pin configuration inputs from a separate configuration block: output enable, push-pull versus open-drain, and pull-up. The block turns the latches and this configuration into pad controls: output value, output enable and pull-up enable. Pad inputs pass through a two-stage synchronizer before they can be read. A host reads in the same cycle as the access and writes on the following clock edge.

Top module: `gpio_bank`

## Requirements
- R1: The port data bytes sit at byte offsets 0x00 (port 0, pins 7..0), 0x04 (port 1, pins 15..8), 0x08 (port 2, pins 23..16) and 0x0A (port 3, pins 28..24). Data bit b of port p belongs to pin 8*p+b.
- R2: When busEn=1 and busWr=1 at a port offset, the latches of that port take busWdata at the next rising clock edge. The latches of every other port keep their values.
- R3: A pin whose cfgOutEn bit is 0 has padOe=0. A push-pull pin (cfgPushPull=1) with cfgOutEn=1 has padOe=1 and padOut equal to its latch.
- R4: An open-drain pin (cfgPushPull=0) with cfgOutEn=1 has padOut=0. Its padOe is 1 when its latch is 0 and 0 when its latch is 1.
- R5: padPu of each pin equals that pin's cfgPullUp bit.
- R6: While busEn=1 and busWr=0 at a port offset, busRdata shows in the same cycle, for each bit, the latch when cfgOutEn is 1 and the synchronized pad level when it is 0.
- R7: A change on padIn reaches the read data after exactly two rising clock edges. It is not visible after one.
- R8: Bits 7..5 of port 3 read as 0, and writes to them have no effect.
- R9: busRdata is 0 when no read is in progress or the offset matches no port. A write to an unmatched offset changes no latch.
- R10: Reset (rstN low) clears every latch and synchronizer stage to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busEn | input | 1 | Access enable |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| cfgOutEn | input | 29 | Per-pin output enable |
| cfgPushPull | input | 29 | Per-pin drive: 1 push-pull, 0 open-drain |
| cfgPullUp | input | 29 | Per-pin pull-up request |
| padIn | input | 29 | Asynchronous pad levels |
| padOut | output | 29 | Pad output value |
| padOe | output | 29 | Pad output enable |
| padPu | output | 29 | Pad pull-up enable |

## Verification
The bench targets the irregular offset of port 3. A decoder that computes offsets as 4*p would write the wrong latches, or none. Writing all ones to port 3 has to read back as 0x1F; a design that stored or returned the missing upper bits would show 0xFF. Open-drain pins are checked with the latch at both 0 and 1, which catches a design that drives high or inverts the enable. The bench also exposes a synchronizer with one stage too few or too many by reading padIn after exactly one edge and then again after two. Reads with mixed output enables check that driven pins return their latches while input pins return pad levels.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PIN_CNT  = 29;
  localparam int PORT_W   = 8;
  localparam int ADDR_W   = 8;
  localparam int PORT_CNT = (PIN_CNT + PORT_W - 1) / PORT_W;

  typedef struct packed {
    logic [PORT_CNT-1:0] wrPort;
    logic [PORT_CNT-1:0] rdPort;
    logic [PORT_W-1:0]   wdata;
  } bankStrobe_t;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= '0;
    else begin
      stageQ[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

  logic [1:0] edgeCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeCnt <= '0;
    else if (edgeCnt != 2'd2) edgeCnt <= edgeCnt + 2'd1;
  end

  // R7
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (STAGES == 2 && edgeCnt == 2'd2) |-> syncOut == $past(asyncIn, 2));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter logic [PORT_CNT-1:0][ADDR_W-1:0] PORT_OFFS = {8'h0A, 8'h08, 8'h04, 8'h00}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PORT_W-1:0] busWdata,
  output bankStrobe_t       strobes
);
  always_comb begin
    strobes.wdata = busWdata;
    for (int p = 0; p < PORT_CNT; p++) begin
      strobes.wrPort[p] = busEn && busWr  && (busAddr == PORT_OFFS[p]);
      strobes.rdPort[p] = busEn && !busWr && (busAddr == PORT_OFFS[p]);
    end
  end

  // R9
  no_idle_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |-> (strobes.wrPort == '0 && strobes.rdPort == '0));
  // R1
  one_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrPort, strobes.rdPort}));
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  bankStrobe_t        strobes,
  input  logic [PIN_CNT-1:0] cfgOutEn,
  input  logic [PIN_CNT-1:0] cfgPushPull,
  input  logic [PIN_CNT-1:0] cfgPullUp,
  input  logic [PIN_CNT-1:0] padIn,
  output logic [PIN_CNT-1:0] padOut,
  output logic [PIN_CNT-1:0] padOe,
  output logic [PIN_CNT-1:0] padPu,
  output logic [PORT_W-1:0]  busRdata
);
  logic [PIN_CNT-1:0] latchQ, latchD, pinSync, rdBits;
  logic [PORT_CNT-1:0][PORT_W-1:0] portRd;

  always_comb begin
    latchD = latchQ;
    for (int i = 0; i < PIN_CNT; i++)
      if (strobes.wrPort[i / PORT_W]) latchD[i] = strobes.wdata[i % PORT_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchQ <= '0;
    else       latchQ <= latchD;
  end

  gpio_bank_sync #(.WIDTH(PIN_CNT), .STAGES(2)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(padIn), .syncOut(pinSync)
  );

  assign padOut = latchQ & cfgPushPull;
  assign padOe  = cfgOutEn & (cfgPushPull | ~latchQ);
  assign padPu  = cfgPullUp;
  assign rdBits = (cfgOutEn & latchQ) | (~cfgOutEn & pinSync);

  for (genvar p = 0; p < PORT_CNT; p++) begin : gPort
    localparam int LO = p * PORT_W;
    localparam int HI = (LO + PORT_W > PIN_CNT) ? PIN_CNT - 1 : LO + PORT_W - 1;
    assign portRd[p] = PORT_W'(rdBits[HI:LO]);

    // R2
    port_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobes.wrPort[p] |=> latchQ[HI:LO] == $past(strobes.wdata[HI-LO:0]));
    // R2
    port_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.wrPort[p] |=> $stable(latchQ[HI:LO]));
  end

  always_comb begin
    busRdata = '0;
    for (int p = 0; p < PORT_CNT; p++)
      if (strobes.rdPort[p]) busRdata = busRdata | portRd[p];
  end

  // R3
  tristate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & ~cfgOutEn) == '0);
  // R4
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padOut & ~cfgPushPull) == '0);
  // R9
  idle_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdPort == '0) |-> busRdata == '0);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter logic [PORT_CNT-1:0][ADDR_W-1:0] PORT_OFFS = {8'h0A, 8'h08, 8'h04, 8'h00}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busEn,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [PORT_W-1:0]  busWdata,
  output logic [PORT_W-1:0]  busRdata,
  input  logic [PIN_CNT-1:0] cfgOutEn,
  input  logic [PIN_CNT-1:0] cfgPushPull,
  input  logic [PIN_CNT-1:0] cfgPullUp,
  input  logic [PIN_CNT-1:0] padIn,
  output logic [PIN_CNT-1:0] padOut,
  output logic [PIN_CNT-1:0] padOe,
  output logic [PIN_CNT-1:0] padPu
);
  bankStrobe_t strobes;

  gpio_bank_ctrl #(.PORT_OFFS(PORT_OFFS)) uCtrl (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .strobes(strobes)
  );

  gpio_bank_dp uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cfgOutEn(cfgOutEn), .cfgPushPull(cfgPushPull), .cfgPullUp(cfgPullUp),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padPu(padPu),
    .busRdata(busRdata)
  );
endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic busEn = 1'b0, busWr = 1'b0;
  logic [7:0] busAddr = '0, busWdata = '0, busRdata;
  logic [28:0] cfgOutEn = '0, cfgPushPull = '1, cfgPullUp = '0, padIn = '0;
  logic [28:0] padOut, padOe, padPu;
  int checks = 0, failures = 0;
  logic [28:0] expLatch = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank u0 (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cfgOutEn(cfgOutEn),
    .cfgPushPull(cfgPushPull), .cfgPullUp(cfgPullUp), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padPu(padPu)
  );

  function automatic logic [7:0] offOf(input int p);
    case (p)
      0: offOf = 8'h00;
      1: offOf = 8'h04;
      2: offOf = 8'h08;
      default: offOf = 8'h0A;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    busEn = 1'b1; busWr = 1'b1; busAddr = off; busWdata = d;
    @(negedge clk);
    busEn = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] off, output logic [7:0] d);
    busEn = 1'b1; busWr = 1'b0; busAddr = off;
    #1 d = busRdata;
    busEn = 1'b0;
  endtask

  function automatic logic [7:0] portOf(input logic [28:0] v, input int p);
    logic [31:0] w;
    w = {3'b000, v};
    portOf = w[p*8 +: 8];
  endfunction

  task automatic testReset();
    logic [7:0] r;
    @(negedge clk);
    check("R10 latches after reset", {3'b0, padOut}, 32'h0);
    check("R3 no drive with outEn low", {3'b0, padOe}, 32'h0);
    cfgOutEn = '1;
    for (int p = 0; p < 4; p++) begin
      busRead(offOf(p), r);
      check("R10 read of reset latch", {24'h0, r}, 32'h0);
    end
  endtask

  task automatic testWriteRead();
    logic [7:0] r;
    logic [7:0] pat [4] = '{8'h5A, 8'hC3, 8'h96, 8'h0F};
    cfgOutEn = '1; cfgPushPull = '1;
    for (int p = 0; p < 4; p++) begin
      busWrite(offOf(p), pat[p]);
      for (int b = 0; b < 8; b++) if (p*8 + b < 29) expLatch[p*8+b] = pat[p][b];
    end
    for (int p = 0; p < 4; p++) begin
      busRead(offOf(p), r);
      check("R1 R6 port readback", {24'h0, r}, {24'h0, portOf(expLatch, p)});
    end
    check("R1 R3 push-pull pad values", {3'b0, padOut}, {3'b0, expLatch});
    check("R3 push-pull enables", {3'b0, padOe}, {3'b0, {29{1'b1}}});
    busWrite(8'h04, 8'hA5);
    expLatch[15:8] = 8'hA5;
    check("R2 other ports untouched", {3'b0, padOut}, {3'b0, expLatch});
  endtask

  task automatic testPort3();
    logic [7:0] r;
    busWrite(8'h0A, 8'hFF);
    expLatch[28:24] = 5'h1F;
    busRead(8'h0A, r);
    check("R8 port 3 upper bits read zero", {24'h0, r}, 32'h1F);
    check("R8 port 3 pads", {27'h0, padOut[28:24]}, 32'h1F);
    busWrite(8'h0A, 8'hE0);
    expLatch[28:24] = 5'h00;
    busRead(8'h0A, r);
    check("R8 upper bit writes ignored", {24'h0, r}, 32'h0);
  endtask

  task automatic testUnmapped();
    logic [7:0] r;
    busWrite(8'h02, 8'hFF);
    busWrite(8'h0C, 8'hFF);
    check("R9 unmapped write no effect", {3'b0, padOut}, {3'b0, expLatch});
    busRead(8'h02, r);
    check("R9 unmapped read zero", {24'h0, r}, 32'h0);
    @(negedge clk);
    #1 check("R9 idle read data zero", {24'h0, busRdata}, 32'h0);
  endtask

  task automatic testOpenDrain();
    busWrite(8'h00, 8'hF0);
    expLatch[7:0] = 8'hF0;
    cfgPushPull[7:0] = 8'h00;
    cfgOutEn[7:0] = 8'hFF;
    #1;
    check("R4 open-drain enables", {24'h0, padOe[7:0]}, 32'h0F);
    check("R4 open-drain values", {24'h0, padOut[7:0]}, 32'h0);
    cfgOutEn[7:0] = 8'h00;
    #1 check("R3 open-drain tristated", {24'h0, padOe[7:0]}, 32'h0);
    cfgPushPull = '1; cfgOutEn = '1;
  endtask

  task automatic testPullUp();
    cfgPullUp = 29'h1234_5678 & {29{1'b1}};
    #1 check("R5 pull-up pass-through", {3'b0, padPu}, {3'b0, 29'h1234_5678 & {29{1'b1}}});
    cfgPullUp = '0;
  endtask

  task automatic testSyncAndMixed();
    logic [7:0] r;
    cfgOutEn[15:8] = 8'h00;
    @(negedge clk);
    padIn[15:8] = 8'h3C;
    @(negedge clk);
    busRead(8'h04, r);
    check("R7 input hidden after one edge", {24'h0, r}, 32'h0);
    @(negedge clk);
    busRead(8'h04, r);
    check("R7 input visible after two edges", {24'h0, r}, 32'h3C);
    cfgOutEn[15:8] = 8'h0F;
    #1 busRead(8'h04, r);
    check("R6 mixed output and input bits", {24'h0, r},
          {24'h0, (expLatch[15:8] & 8'h0F) | (8'h3C & 8'hF0)});
    cfgOutEn = '1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWriteRead();
    testPort3();
    testUnmapped();
    testOpenDrain();
    testPullUp();
    testSyncAndMixed();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule